// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the external bus cycles of a small microcontroller that sees two separate 64 KB spaces: one for code and one for data. The low address byte and the data byte take turns on one 8-bit port. The high address byte sits on a second port for the whole cycle. A one-clock address-latch strobe lets a transparent latch on the board capture the low address before the shared port turns around.

Code fetches read through an active-low program strobe. Data accesses use separate active-low read and write strobes. A configuration input decides how the lowest 4 KB of code space is served. When it is high, fetches in that range go to an internal ROM port. They return data one clock later and show nothing on the external pins.

The core issues one request at a time with a valid/kind/address/write-data group. It may do so only while `req_ready` is high. Read results come back as a one-clock `resp_valid` pulse carrying the data.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, and whenever the bus is idle, the following hold: all three strobes are high, `ale` is low, the shared port is not driven and `req_ready` is high.
- R2: An external cycle starts one clock after acceptance. In that first clock, `ale` is high and the shared port drives the low address byte. `ale` stays high for exactly one clock per cycle.
- R3: In the clock after `ale` falls, the shared port still drives the low address byte and no strobe is active.
- R4: In the third clock of a read or fetch cycle, the shared port is released. In the fourth clock, the selected strobe is low. It is high again in the fifth clock. A strobe is never low while the shared port is driven for a read.
- R5: Read data is sampled from `port_lo_in` on the clock edge that ends the strobe-low clock. It appears on `resp_data` with `resp_valid` high during the fifth clock.
- R6: In a write cycle (kind 2'b10), the shared port drives the write data from the third clock through the fifth. `data_wr_n` is low in the fourth clock only. No response is produced.
- R7: Kind 2'b00 (fetch) uses `prog_rd_n`, and kind 2'b01 (data read) uses `data_rd_n`. At most one of the three strobes is low in any clock.
- R8: `port_hi` carries the high address byte for the entire cycle, even if the request inputs change while the cycle runs.
- R9: With `int_rom_en` low, every fetch runs as an external cycle, including fetches below 0x1000.
- R10: With `int_rom_en` high, a fetch below 0x1000 presents `addr[11:0]` on `rom_addr` in the accepting clock. It drives no strobe and no `ale`. It returns the `rom_rdata` byte with `resp_valid` in the next clock. A fetch at 0x1000 runs externally.
- R11: Data reads and writes always run externally, whatever their address and whatever `int_rom_en` is.
- R12: `req_ready` is low for the five clocks of an external cycle. Requests presented while it is low are ignored, and so is kind 2'b11 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_rom_en | input | 1 | High: fetches below 4 KB go to the internal ROM port |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 ignored |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block idle, request may be presented |
| resp_valid | output | 1 | One-clock pulse with read result |
| resp_data | output | 8 | Read result |
| rom_addr | output | 12 | Internal ROM address |
| rom_rdata | input | 8 | Internal ROM data, combinational from `rom_addr` |
| ale | output | 1 | Address latch strobe, active high |
| prog_rd_n | output | 1 | Code read strobe, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |
| port_lo_out | output | 8 | Shared address-low/data port, output value |
| port_lo_oe | output | 1 | Shared port output enable |
| port_lo_in | input | 8 | Shared port input value |
| port_hi | output | 8 | High address byte |

## Verification
The assertions check the pin rules that must hold in every clock. At most one strobe is low, and the bus is quiet when idle. `ale` lasts one clock and is driven with the port. A strobe is low for one clock, exactly three clocks after `ale`. A read strobe never meets a driven port, and a write strobe always does. The high byte is stable through a cycle. Whether the right address byte, write data or sampled read byte appears at the right clock can only be shown by the bench. The same holds for the internal/external routing at the 4 KB boundary and for the ignoring of requests during a cycle. The bench covers these with its latch-and-memory model and its response scoreboard.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_DRD   = 2'b01,
    K_DWR   = 2'b10,
    K_NONE  = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HOLD = 3'd2,
    PH_TURN = 3'd3,
    PH_STRB = 3'd4,
    PH_REL  = 3'd5
  } phase_e;
endpackage

// File: rtl/xbus_phase_fsm.sv
`timescale 1ns/1ps
module xbus_phase_fsm
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_HOLD;
      PH_HOLD: phase_d = PH_TURN;
      PH_TURN: phase_d = PH_STRB;
      PH_STRB: phase_d = PH_REL;
      PH_REL:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R2: a started cycle always walks forward into the address phase
  p_start_enters_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && start) |=> (phase_q == PH_ADDR));
endmodule

// File: rtl/xbus_pins.sv
`timescale 1ns/1ps
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  phase_e          phase,
  input  logic [1:0]      kind,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic            ale,
  output logic            prog_rd_n,
  output logic            data_rd_n,
  output logic            data_wr_n,
  output logic [DW-1:0]   port_lo_out,
  output logic            port_lo_oe,
  output logic [AW-DW-1:0] port_hi
);
  logic addr_phase, data_phase, is_wr;

  always_comb begin
    addr_phase  = (phase == PH_ADDR) || (phase == PH_HOLD);
    data_phase  = (phase == PH_TURN) || (phase == PH_STRB) || (phase == PH_REL);
    is_wr       = (kind == K_DWR);
    ale         = (phase == PH_ADDR);
    port_lo_out = addr_phase ? addr[DW-1:0] : wdata;
    port_lo_oe  = addr_phase || (data_phase && is_wr);
    prog_rd_n   = !((phase == PH_STRB) && (kind == K_FETCH));
    data_rd_n   = !((phase == PH_STRB) && (kind == K_DRD));
    data_wr_n   = !((phase == PH_STRB) && is_wr);
    port_hi     = addr[AW-1:DW];
  end
endmodule

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int ROM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_rom_en,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DW-1:0]     resp_data,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DW-1:0]     rom_rdata,
  output logic              ale,
  output logic              prog_rd_n,
  output logic              data_rd_n,
  output logic              data_wr_n,
  output logic [DW-1:0]     port_lo_out,
  output logic              port_lo_oe,
  input  logic [DW-1:0]     port_lo_in,
  output logic [AW-DW-1:0]  port_hi
);
  localparam int HW = AW - ROM_AW;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s_n  <= rst_s1_q;
    end
  end

  phase_e          phase;
  logic            accept, int_hit, start_ext, load_req;
  logic [1:0]      kind_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            resp_v_d;
  logic [DW-1:0]   resp_data_d;

  always_comb begin
    req_ready   = (phase == PH_IDLE);
    accept      = req_ready && req_valid && (req_kind != K_NONE);
    int_hit     = int_rom_en && (req_kind == K_FETCH) &&
                  (req_addr[AW-1:ROM_AW] == {HW{1'b0}});
    start_ext   = accept && !int_hit;
    load_req    = start_ext;
    rom_addr    = req_addr[ROM_AW-1:0];
    resp_v_d    = (accept && int_hit) ||
                  ((phase == PH_STRB) && (kind_q != K_DWR));
    resp_data_d = (accept && int_hit) ? rom_rdata : port_lo_in;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      kind_q  <= K_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_req) begin
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= resp_v_d;
      if (resp_v_d) resp_data <= resp_data_d;
    end
  end

  xbus_phase_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_s_n),
    .start (start_ext),
    .phase (phase)
  );

  xbus_pins #(.AW(AW), .DW(DW)) u_pins (
    .phase       (phase),
    .kind        (kind_q),
    .addr        (addr_q),
    .wdata       (wdata_q),
    .ale         (ale),
    .prog_rd_n   (prog_rd_n),
    .data_rd_n   (data_rd_n),
    .data_wr_n   (data_wr_n),
    .port_lo_out (port_lo_out),
    .port_lo_oe  (port_lo_oe),
    .port_hi     (port_hi)
  );

  // pin protocol checks
  logic strb_act;
  assign strb_act = !(prog_rd_n && data_rd_n && data_wr_n);

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $countones({~prog_rd_n, ~data_rd_n, ~data_wr_n}) <= 1);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_ready |-> (!strb_act && !ale && !port_lo_oe));
  p_ale_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    ale |=> !ale);
  p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    ale |-> port_lo_oe);
  p_hold_after_ale_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ale |=> (port_lo_oe && !strb_act));
  p_strobe_spacing_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(strb_act) |-> $past(ale, 3));
  p_strobe_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    strb_act |=> !strb_act);
  p_read_released_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!prog_rd_n || !data_rd_n) |-> !port_lo_oe);
  p_write_driven_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !data_wr_n |-> port_lo_oe);
  p_hi_stable_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!req_ready && $past(!req_ready)) |-> $stable(port_hi));
  p_busy_five_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ale) |-> $past(req_ready));
endmodule

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_ctrl_bench;
  import xbus_pkg::*;

  logic        clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, int_rom_en, req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, resp_valid;
  logic [7:0]  resp_data;
  logic [11:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic        ale, prog_rd_n, data_rd_n, data_wr_n, port_lo_oe;
  logic [7:0]  port_lo_out, port_lo_in, port_hi;

  xbus_ctrl u_xbus_ctrl (.*);

  int vectors = 0, misses = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] exp_mem[256];

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] code_f(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction
  function automatic logic [7:0] rom_f(logic [11:0] a);
    return ~a[7:0] ^ {a[11:8], a[11:8]};
  endfunction

  // board model: address latch, code memory, data memory, ROM
  logic [7:0]  lat;
  logic [7:0]  dmem[256];
  logic [15:0] wr_seen_addr = '0;
  always_latch if (ale) lat = port_lo_out;
  assign port_lo_in = !prog_rd_n ? code_f({port_hi, lat}) :
                      !data_rd_n ? dmem[lat] : 8'hEE;
  assign rom_rdata  = rom_f(rom_addr);
  always @(posedge clk) if (!data_wr_n) begin
    dmem[lat]    <= port_lo_out;
    wr_seen_addr <= {port_hi, lat};
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && resp_valid) begin
    if (exp_q.size() == 0) chk(0, "R5 unexpected response", resp_data, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(resp_data == e, "R5/R10 response data", resp_data, e);
    end
  end

  task automatic ext_access(logic [1:0] k, logic [15:0] a, logic [7:0] wd, bit poke);
    bit rd;
    rd = (k != K_DWR);
    @(negedge clk);
    chk(req_ready, "R12 ready before request", req_ready, 1);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd;
    if (k == K_FETCH) exp_q.push_back(code_f(a));
    else if (k == K_DRD) exp_q.push_back(exp_mem[a[7:0]]);
    else exp_mem[a[7:0]] = wd;
    @(negedge clk);  // address phase
    chk(ale == 1, "R2 ale high", ale, 1);
    chk(port_lo_oe && port_lo_out == a[7:0], "R2 low address on port", port_lo_out, a[7:0]);
    chk(port_hi == a[15:8], "R8 high address", port_hi, a[15:8]);
    chk(!req_ready, "R12 busy", req_ready, 0);
    if (poke) begin req_kind = K_DWR; req_addr = ~a; req_wdata = 8'h00; end
    else req_valid = 0;
    @(negedge clk);  // hold phase
    chk(!ale && port_lo_oe && port_lo_out == a[7:0], "R3 low address held", port_lo_out, a[7:0]);
    chk(prog_rd_n && data_rd_n && data_wr_n, "R3 no strobe", {prog_rd_n, data_rd_n, data_wr_n}, 7);
    req_valid = 0;
    @(negedge clk);  // turnaround phase
    chk(port_lo_oe == !rd, "R4/R6 port direction", port_lo_oe, !rd);
    if (!rd) chk(port_lo_out == wd, "R6 write data", port_lo_out, wd);
    chk(prog_rd_n && data_rd_n && data_wr_n, "R4 no strobe yet", {prog_rd_n, data_rd_n, data_wr_n}, 7);
    @(negedge clk);  // strobe phase
    chk({prog_rd_n, data_rd_n, data_wr_n} == {k != K_FETCH, k != K_DRD, k != K_DWR},
        "R7 strobe selection", {prog_rd_n, data_rd_n, data_wr_n},
        {k != K_FETCH, k != K_DRD, k != K_DWR});
    chk(port_hi == a[15:8], "R8 high address in strobe", port_hi, a[15:8]);
    if (!rd) chk(port_lo_oe && port_lo_out == wd, "R6 write data in strobe", port_lo_out, wd);
    @(negedge clk);  // release phase
    chk(prog_rd_n && data_rd_n && data_wr_n, "R4 strobe released", {prog_rd_n, data_rd_n, data_wr_n}, 7);
    chk(resp_valid == rd, "R5/R6 response presence", resp_valid, rd);
    if (!rd) chk(port_lo_oe && port_lo_out == wd, "R6 write data held", port_lo_out, wd);
    @(negedge clk);
    chk(req_ready && !ale && !port_lo_oe, "R1/R12 idle again", req_ready, 1);
    chk(!resp_valid, "R12 poked request ignored", resp_valid, 0);
    if (!rd) chk(wr_seen_addr == a, "R6 write address", wr_seen_addr, a);
  endtask

  task automatic int_fetch(logic [15:0] a);
    @(negedge clk);
    chk(req_ready, "R10 ready", req_ready, 1);
    req_valid = 1; req_kind = K_FETCH; req_addr = a;
    #0.5;
    chk(rom_addr == a[11:0], "R10 rom address", rom_addr, a[11:0]);
    exp_q.push_back(rom_f(a[11:0]));
    @(negedge clk);
    req_valid = 0;
    chk(resp_valid, "R10 response next clock", resp_valid, 1);
    chk(prog_rd_n && data_rd_n && data_wr_n && !ale && req_ready, "R10 no external activity",
        {prog_rd_n, data_rd_n, data_wr_n, ale}, 14);
  endtask

  initial begin
    rst_n = 0; int_rom_en = 1; req_valid = 0; req_kind = K_FETCH;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready && !ale && prog_rd_n && data_rd_n && data_wr_n && !port_lo_oe && !resp_valid,
        "R1 reset state", {req_ready, ale, port_lo_oe}, 4);
    ext_access(K_DWR, 16'h2345, 8'hA5, 0);
    ext_access(K_DWR, 16'h0010, 8'h3C, 0);   // R11 low data address stays external
    ext_access(K_DWR, 16'h80FF, 8'h5A, 0);
    ext_access(K_DRD, 16'h2345, 8'h00, 0);
    ext_access(K_DRD, 16'h0010, 8'h00, 0);   // R11
    ext_access(K_DRD, 16'h80FF, 8'h00, 1);   // R12 poke during cycle
    int_fetch(16'h0000);
    int_fetch(16'h0FFF);
    int_fetch(16'h0ABC);
    ext_access(K_FETCH, 16'h1000, 8'h00, 0); // R10 boundary external
    ext_access(K_FETCH, 16'hFE01, 8'h00, 1);
    int_rom_en = 0;
    ext_access(K_FETCH, 16'h0123, 8'h00, 0); // R9
    ext_access(K_FETCH, 16'h0FFF, 8'h00, 0); // R9
    @(negedge clk);
    req_valid = 1; req_kind = K_NONE; req_addr = 16'h0042;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready && !ale && !resp_valid, "R12 kind 11 ignored", {req_ready, ale, resp_valid}, 4);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++; misses++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule